// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a synthesizable behavioural model of a synchronous burst static RAM with 18-bit words split into two 9-bit byte lanes. The depth is a parameter, so a small instance can stand in for a much larger part in simulation. Every access begins on a rising clock edge. Three chip-select inputs qualify two address strobes. One strobe is meant for a processor and one for a memory controller. An advance input then walks a four-beat burst or suspends it on the current word.

The low two address bits come from a 2-bit burst counter. A static strap picks between linear order and interleaved order. A second strap picks between two read paths. Flow-through returns data right after the access edge. Pipelined adds one output register stage. The pad-side tri-state driver is split into a data output and a driver enable. That enable is gated at once by an active-low output enable. A sleep input stops all accesses and keeps the stored data and the burst position.

Top module: `sbsram_core`

## Requirements
- R1: The device is selected only when sel0_n is 0, sel1 is 1 and sel2_n is 0. A strobe cycle that is not ignored (see R3) with any other select pattern is a deselect. It ends the burst, and in flow-through mode rdata_oe is 0 after that edge.
- R2: cpu_strb_n low with sel0_n low and the device selected begins a read at addr. This holds whatever wr_all_n, wr_lane_n and lane_wr_n say.
- R3: While sel0_n is high, cpu_strb_n has no effect. ctl_strb_n low then deselects. ctl_strb_n high lets an active burst continue or suspend as in R5.
- R4: ctl_strb_n low, when the device is selected and cpu_strb_n is not acting, loads addr as the burst start. It begins a write if any lane write is requested (R9) and a read otherwise.
- R5: During an active burst with neither strobe acting, adv_n low moves to the next burst address and adv_n high repeats the current one. The cycle writes if a lane write is requested and reads otherwise.
- R6: Only the two low address bits change within a burst. With ilv_order high the low bits are start XOR count. With ilv_order low they are (start + count) mod 4. The count is 0 at the start, 1, 2, 3, then wraps to 0.
- R7: With pipe_mode low, data read on edge k is on rdata after edge k. With pipe_mode high it appears after edge k+1.
- R8: oe_n acts without a clock. While it is high, rdata_oe is 0.
- R9: Lane 0 is bits 8:0, controlled by lane_wr_n[0]. Lane 1 is bits 17:9, controlled by lane_wr_n[1]. wr_all_n low writes both lanes. Otherwise wr_lane_n low writes each lane whose lane_wr_n bit is low. Otherwise there is no write.
- R10: While sleep is high, no edge reads or writes, rdata_oe is 0, and the burst position and stored data are kept.
- R11: After reset no burst is active and rdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| sel0_n | input | 1 | Active-low select, also gates the processor strobe |
| sel1 | input | 1 | Active-high select |
| sel2_n | input | 1 | Active-low select |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | AW | Word address |
| ilv_order | input | 1 | Strap: 1 interleaved, 0 linear burst order |
| pipe_mode | input | 1 | Strap: 1 pipelined, 0 flow-through read path |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_lane_n | input | 1 | Enable per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power sleep, no accesses |
| wdata | input | LANES*LANE_W | Write data, taken on the edge |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_oe | output | 1 | Data bus driver enable |

## Verification
A wrong burst counter or a wrong start latch shows up as a wrong word on rdata. In flow-through mode this is visible just after the bad edge, and in pipelined mode one clock later. A wrong lane mask or a write that slips through during sleep stays hidden until the word is read back, so each write pattern is followed by a read burst over the same group. Bad select or strobe decoding shows as rdata_oe staying high or dropping on the wrong cycle. The bench compares both outputs with a behavioural model every clock, so the first bad cycle is reported.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_BEGIN_RD,
    OP_BEGIN_WR,
    OP_NEXT,
    OP_HOLD
  } acc_op_e;

  // Low address bits of a burst beat from the start bits and the beat count.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] count,
    input logic               interleave
  );
    if (interleave) return start ^ count;
    return start + count;
  endfunction

  function automatic logic is_continue(input acc_op_e op);
    return (op == OP_NEXT) || (op == OP_HOLD);
  endfunction

endpackage

// File: rtl/sbsram_cmd_dec.sv
module sbsram_cmd_dec
  import sbsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             adv_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             sleep,
  input  logic             burst_act,
  output acc_op_e          op,
  output logic [LANES-1:0] lane_we,
  output logic             do_read,
  output logic             do_write
);

  logic             selected;
  logic             cpu_takes;
  logic [LANES-1:0] lane_req;
  logic             any_req;

  assign selected  = !sel0_n && sel1 && !sel2_n;
  assign cpu_takes = !cpu_strb_n && !sel0_n;

  always_comb begin
    if (!wr_all_n)       lane_req = '1;
    else if (!wr_lane_n) lane_req = ~lane_wr_n;
    else                 lane_req = '0;
  end
  assign any_req = |lane_req;

  always_comb begin
    op = OP_IDLE;
    if (sleep)              op = OP_IDLE;
    else if (cpu_takes)     op = selected ? OP_BEGIN_RD : OP_DESEL;
    else if (!ctl_strb_n)   op = !selected ? OP_DESEL :
                                 (any_req ? OP_BEGIN_WR : OP_BEGIN_RD);
    else if (burst_act)     op = adv_n ? OP_HOLD : OP_NEXT;
  end

  assign do_write = (op == OP_BEGIN_WR) || (is_continue(op) && any_req);
  assign do_read  = (op == OP_BEGIN_RD) || (is_continue(op) && !any_req);
  assign lane_we  = do_write ? lane_req : '0;

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_op_e       op,
  input  logic [AW-1:0] addr,
  input  logic          ilv_order,
  output logic [AW-1:0] acc_addr,
  output logic          burst_act
);

  localparam int HI_W = AW - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_eff;
  logic               act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      unique case (op)
        OP_BEGIN_RD, OP_BEGIN_WR: begin
          hi_q    <= addr[AW-1:BURST_W];
          start_q <= addr[BURST_W-1:0];
          cnt_q   <= '0;
          act_q   <= 1'b1;
        end
        OP_NEXT:  cnt_q <= cnt_eff;
        OP_DESEL: act_q <= 1'b0;
        default: ;
      endcase
    end
  end

  assign cnt_eff = (op == OP_NEXT) ? cnt_q + 1'b1 : cnt_q;

  always_comb begin
    if (op == OP_BEGIN_RD || op == OP_BEGIN_WR) acc_addr = addr;
    else acc_addr = {hi_q, burst_low(start_q, cnt_eff, ilv_order)};
  end

  assign burst_act = act_q;

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [AW-1:0]           acc_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_l;

    always_ff @(posedge clk) begin
      if (lane_we[l]) mem[acc_addr] <= wdata[l*LANE_W +: LANE_W];
      if (rd_en)      q_l <= mem[acc_addr];
    end

    assign rd_q[l*LANE_W +: LANE_W] = q_l;
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    adv_n,
  input  logic [AW-1:0]           addr,
  input  logic                    ilv_order,
  input  logic                    pipe_mode,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DW = LANES * LANE_W;

  acc_op_e          op;
  logic [LANES-1:0] lane_we;
  logic             ev_read;
  logic             ev_write;
  logic             burst_act;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    flow_q;
  logic [DW-1:0]    pipe_q;
  logic             vld_flow;
  logic             vld_pipe;
  logic             vld_sel;
  logic [DW-1:0]    data_sel;

  sbsram_cmd_dec #(.LANES(LANES)) dec_i (
    .sel0_n     (sel0_n),
    .sel1       (sel1),
    .sel2_n     (sel2_n),
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .adv_n      (adv_n),
    .wr_all_n   (wr_all_n),
    .wr_lane_n  (wr_lane_n),
    .lane_wr_n  (lane_wr_n),
    .sleep      (sleep),
    .burst_act  (burst_act),
    .op         (op),
    .lane_we    (lane_we),
    .do_read    (ev_read),
    .do_write   (ev_write)
  );

  sbsram_burst #(.AW(AW)) burst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .addr      (addr),
    .ilv_order (ilv_order),
    .acc_addr  (acc_addr),
    .burst_act (burst_act)
  );

  sbsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk      (clk),
    .acc_addr (acc_addr),
    .lane_we  (lane_we),
    .wdata    (wdata),
    .rd_en    (ev_read),
    .rd_q     (flow_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_flow <= 1'b0;
      vld_pipe <= 1'b0;
    end else begin
      vld_flow <= ev_read;
      vld_pipe <= vld_flow;
    end
  end

  always_ff @(posedge clk) pipe_q <= flow_q;

  assign vld_sel  = pipe_mode ? vld_pipe : vld_flow;
  assign data_sel = pipe_mode ? pipe_q : flow_q;
  assign rdata_oe = vld_sel && !oe_n && !sleep;
  assign rdata    = rdata_oe ? data_sel : '0;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk
  import sbsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             rdata_oe,
  input acc_op_e          op,
  input logic [AW-1:0]    acc_addr,
  input logic [LANES-1:0] lane_we,
  input logic             ev_read,
  input logic             ev_write,
  input logic             vld_flow,
  input logic             vld_pipe,
  input logic             burst_act
);

  p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> (!vld_flow && !burst_act));

  p_begin_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEGIN_RD) |-> (ev_read && lane_we == '0));

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BEGIN_WR) |=> burst_act);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |-> (acc_addr == $past(acc_addr)));

  p_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NEXT) |-> (acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));

  p_pipe_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_flow |=> vld_pipe);

  p_pipe_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_flow |=> !vld_pipe);

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_read && ev_write));

  p_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_write |-> (lane_we != '0));

  p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0 && !rdata_oe && !ev_read));

endmodule

bind sbsram_core sbsram_chk #(.AW(AW), .LANES(LANES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_n      (oe_n),
  .sleep     (sleep),
  .rdata_oe  (rdata_oe),
  .op        (op),
  .acc_addr  (acc_addr),
  .lane_we   (lane_we),
  .ev_read   (ev_read),
  .ev_write  (ev_write),
  .vld_flow  (vld_flow),
  .vld_pipe  (vld_pipe),
  .burst_act (burst_act)
);

// File: tb/sbsram_core_tb_top.sv
module sbsram_core_tb_top;

  localparam int AW = 6;
  localparam int DW = 18;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, sel0_n, sel1, sel2_n, cpu_strb_n, ctl_strb_n, adv_n;
  logic [AW-1:0] addr;
  logic          ilv_order, pipe_mode, wr_all_n, wr_lane_n, oe_n, sleep;
  logic [1:0]    lane_wr_n;
  logic [DW-1:0] wdata, rdata;
  logic          rdata_oe;

  sbsram_core #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .addr(addr), .ilv_order(ilv_order), .pipe_mode(pipe_mode),
    .wr_all_n(wr_all_n), .wr_lane_n(wr_lane_n), .lane_wr_n(lane_wr_n),
    .oe_n(oe_n), .sleep(sleep), .wdata(wdata), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  // Behavioural reference state
  logic [DW-1:0] m_mem [0:(1<<AW)-1];
  bit            m_act, m_v1, m_v2;
  int            m_hi, m_start, m_cnt;
  logic [DW-1:0] m_d1, m_d2;
  int            n_chk = 0, n_fail = 0;
  string         cur_req = "R11";
  bit            done = 1'b0;

  // 0 idle, 1 deselect, 2 begin read, 3 begin write, 4 next, 5 hold
  function automatic int m_lanes();
    if (!wr_all_n) return 3;
    if (!wr_lane_n) return int'(~lane_wr_n) & 3;
    return 0;
  endfunction

  function automatic int m_op();
    bit chosen = (sel0_n == 0) && (sel1 == 1) && (sel2_n == 0);
    if (sleep) return 0;
    if (cpu_strb_n == 0 && sel0_n == 0) return chosen ? 2 : 1;
    if (ctl_strb_n == 0) begin
      if (!chosen) return 1;
      return (m_lanes() != 0) ? 3 : 2;
    end
    if (m_act) return adv_n ? 5 : 4;
    return 0;
  endfunction

  function automatic int m_low(int s, int c);
    if (ilv_order) return s ^ c;
    return (s + c) % 4;
  endfunction

  task automatic m_edge();
    int op = m_op();
    int ln = m_lanes();
    int a = 0;
    bit cont = (op == 4 || op == 5);
    bit wr = (op == 3) || (cont && ln != 0);
    bit rd = (op == 2) || (cont && ln == 0);
    if (op == 2 || op == 3) a = int'(addr);
    else if (op == 4) a = m_hi * 4 + m_low(m_start, (m_cnt + 1) % 4);
    else a = m_hi * 4 + m_low(m_start, m_cnt);
    m_v2 = m_v1;
    m_d2 = m_d1;
    m_v1 = rd;
    if (rd) m_d1 = m_mem[a];
    if (wr && (ln & 1) != 0) m_mem[a][8:0]  = wdata[8:0];
    if (wr && (ln & 2) != 0) m_mem[a][17:9] = wdata[17:9];
    if (op == 2 || op == 3) begin
      m_hi = int'(addr) / 4; m_start = int'(addr) % 4; m_cnt = 0; m_act = 1;
    end else if (op == 4) m_cnt = (m_cnt + 1) % 4;
    else if (op == 1) m_act = 0;
  endtask

  task automatic check_out();
    bit            e_oe = (pipe_mode ? m_v2 : m_v1) && !oe_n && !sleep;
    logic [DW-1:0] e_d  = pipe_mode ? m_d2 : m_d1;
    n_chk++;
    if (rdata_oe !== e_oe || (e_oe && rdata !== e_d)) begin
      n_fail++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
               cur_req, rdata_oe, rdata, e_oe, e_d);
    end
  endtask

  task automatic step();
    #1 check_out();
    @(posedge clk);
    m_edge();
    @(negedge clk);
  endtask

  task automatic idle_in();
    sel0_n = 0; sel1 = 1; sel2_n = 0;
    cpu_strb_n = 1; ctl_strb_n = 1; adv_n = 1;
    wr_all_n = 1; wr_lane_n = 1; lane_wr_n = 2'b11;
    oe_n = 0; sleep = 0;
  endtask

  task automatic read_burst(int a, bit by_cpu, int beats);
    idle_in(); addr = AW'(a);
    if (by_cpu) cpu_strb_n = 0; else ctl_strb_n = 0;
    step();
    idle_in(); adv_n = 0;
    for (int i = 0; i < beats; i++) step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; idle_in(); addr = '0; wdata = '0;
    ilv_order = 0; pipe_mode = 0;
    m_act = 0; m_v1 = 0; m_v2 = 0; m_d1 = '0; m_d2 = '0;
    m_hi = 0; m_start = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    cur_req = "R11"; #1 check_out();
    rst_n = 1;
    @(negedge clk);

    // R4: fill every word with controller-strobed write bursts
    cur_req = "R4";
    for (int g = 0; g < (1 << AW); g += 4) begin
      idle_in(); ctl_strb_n = 0; wr_all_n = 0; addr = AW'(g);
      wdata = DW'($urandom); step();
      for (int b = 0; b < 3; b++) begin
        idle_in(); adv_n = 0; wr_all_n = 0; wdata = DW'($urandom); step();
      end
    end

    // R2: processor strobe reads even with write enables asserted
    cur_req = "R2";
    idle_in(); cpu_strb_n = 0; wr_all_n = 0; addr = 8; step();
    cur_req = "R5";
    idle_in(); adv_n = 0; repeat (3) step();
    idle_in(); repeat (2) step();

    // R6: interleaved and linear orders, including wrap
    cur_req = "R6";
    ilv_order = 1; read_burst(9, 1, 5);
    ilv_order = 0; read_burst(14, 0, 5);

    // R7: pipelined output path
    cur_req = "R7";
    pipe_mode = 1; read_burst(22, 1, 4);
    idle_in(); ctl_strb_n = 0; sel1 = 0; step();
    idle_in(); repeat (2) step();
    pipe_mode = 0;

    // R9: lane writes, then read back
    cur_req = "R9";
    idle_in(); ctl_strb_n = 0; wr_lane_n = 0; lane_wr_n = 2'b10;
    addr = 20; wdata = 18'h2a5a5; step();
    idle_in(); adv_n = 0; wr_lane_n = 0; lane_wr_n = 2'b01;
    wdata = 18'h15a5a; step();
    idle_in(); adv_n = 1; wr_lane_n = 1; lane_wr_n = 2'b00;
    wdata = 18'h3ffff; step();
    idle_in(); ctl_strb_n = 0; lane_wr_n = 2'b00; addr = 24;
    wdata = 18'h00001; step();
    read_burst(20, 1, 3);
    read_burst(24, 1, 1);

    // R3: sel0_n high hides the processor strobe; controller strobe deselects
    cur_req = "R3";
    read_burst(0, 1, 1);
    idle_in(); sel0_n = 1; cpu_strb_n = 0; adv_n = 0; addr = 40; step();
    idle_in(); sel0_n = 1; ctl_strb_n = 0; step();
    idle_in(); adv_n = 0; step();

    // R1: wrong select patterns deselect
    cur_req = "R1";
    read_burst(32, 1, 1);
    idle_in(); ctl_strb_n = 0; sel1 = 0; step();
    read_burst(36, 0, 1);
    idle_in(); cpu_strb_n = 0; sel2_n = 1; step();
    idle_in(); adv_n = 0; step();

    // R8: output enable acts between clock edges
    cur_req = "R8";
    read_burst(44, 1, 1);
    idle_in(); oe_n = 0; #1 check_out();
    oe_n = 1; #1 check_out();
    oe_n = 0; #1 check_out();
    @(negedge clk);

    // R10: sleep blocks accesses and keeps the burst position
    cur_req = "R10";
    read_burst(48, 1, 1);
    idle_in(); sleep = 1; ctl_strb_n = 0; wr_all_n = 0; addr = 48;
    wdata = 18'h0beef; step(); step();
    idle_in(); adv_n = 0; repeat (3) step();
    read_burst(48, 1, 1);

    // R5: mixed random traffic
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      if (i % 250 == 0) begin
        idle_in(); step();
        ilv_order = $urandom_range(0, 1);
        pipe_mode = $urandom_range(0, 1);
      end
      sel0_n     = ($urandom_range(0, 7) == 0);
      sel1       = ($urandom_range(0, 7) != 0);
      sel2_n     = ($urandom_range(0, 7) == 0);
      cpu_strb_n = ($urandom_range(0, 5) != 0);
      ctl_strb_n = ($urandom_range(0, 5) != 0);
      adv_n      = $urandom_range(0, 1);
      wr_all_n   = ($urandom_range(0, 4) != 0);
      wr_lane_n  = $urandom_range(0, 1);
      lane_wr_n  = 2'($urandom_range(0, 3));
      oe_n       = ($urandom_range(0, 5) == 0);
      sleep      = ($urandom_range(0, 30) == 0);
      addr       = AW'($urandom);
      wdata      = DW'($urandom);
      step();
    end
    idle_in(); step(); step();
    finish_run();
  end

endmodule